// File: doc/BRIEF.md
# SD Command Framer and Response Checker

This block drives the command line of an SD/MMC card interface. On a start pulse it takes a 6-bit command index and a 32-bit argument and builds a 48-bit command token. The token is a start bit of 0, a transmission bit of 1, the index, the argument sent most significant bit first, a CRC7 computed over those 40 bits and a closing 1. It shifts the token out one bit per clock on `cmd_out`. `cmd_oe` is high while the token is on the line.

The class of the card's reply is chosen per command on `rsp_class`. The engine then waits for a start bit on `rsp_in`, deserializes either 48 or 136 bits and checks the framing and the CRC7. It presents the payload as 32-bit big-endian words with one error flag. A reply class that carries no valid CRC skips the CRC comparison. A busy-type reply also waits for the card to release the data-0 line. The clock `clk` is the card clock, so each clock cycle carries one bit in each direction.

Top module: `sdc_cmd_engine`

## Requirements
- R1: After `start` is sampled high in idle, `cmd_oe` is high for exactly 48 cycles, starting the next cycle. During those cycles `cmd_out` carries, MSB first: 0, 1, the 6-bit index, the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, register cleared to 0) over those first 40 bits, and a final 1.
- R2: Outside a token `cmd_oe` is 0 and `cmd_out` rests at 1; after reset the engine is idle, with `busy`, `done`, all error flags and all response words at 0.
- R3: `rsp_class` encodes 0 = no reply, 1 = short with CRC, 2 = short without CRC check, 3 = short with busy, 4 = long; the codes 5 to 7 act as 0. With no reply, `done` pulses on the clock edge after the last token bit, with no error flag set and the response words left unchanged.
- R4: The reply start bit (a 0 on `rsp_in`) must be sampled on one of the 64 clock edges after the edge that ends the token. Otherwise `err_timeout` is set with `done` on the 64th of those edges, and the response words are left unchanged.
- R5: A short reply is 48 bits; `rsp_w0` is bits 39..8 of it (reply bytes 1 to 4, big-endian), and `rsp_w1` to `rsp_w3` read 0.
- R6: A long reply is 136 bits; its 16 bytes after the first byte appear on `rsp_w0` (bytes 1 to 4) through `rsp_w3` (bytes 13 to 16), each word big-endian.
- R7: `err_frame` is set when either of the two top bits of the first reply byte is 1, or when the last reply bit is 0.
- R8: `err_crc` is set when bits 7..1 of the reply differ from a CRC7 over its first 40 bits (short classes) or over bits 127..8 (long class). Class 2 never sets `err_crc`.
- R9: At most one error flag is set, with priority timeout, then frame, then CRC. The flags are cleared when a command is accepted and hold their value while idle.
- R10: For class 3, `done` is delayed after the reply until `dat0_in` is sampled high.
- R11: `done` is a single-cycle pulse. For classes other than 3, it rises on the clock edge after the edge that samples the last reply bit.
- R12: `busy` is high from the edge that accepts `start` until the edge that raises `done`. A `start` while `busy` is high is ignored and leaves the token on the line unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command when idle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_class | input | 3 | Expected reply class |
| rsp_in | input | 1 | Serial reply from the card |
| dat0_in | input | 1 | Data-0 line level, low while card is busy |
| cmd_out | output | 1 | Serial token to the card |
| cmd_oe | output | 1 | Token driver enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | Single-cycle completion pulse |
| err_timeout | output | 1 | No reply start bit in the window |
| err_frame | output | 1 | Bad reply framing bits |
| err_crc | output | 1 | Reply CRC7 mismatch |
| rsp_w0 | output | 32 | Reply word 0 |
| rsp_w1 | output | 32 | Reply word 1 |
| rsp_w2 | output | 32 | Reply word 2 |
| rsp_w3 | output | 32 | Reply word 3 |

## Verification
Token bit k is visible in the cycle after the k-th edge following the accepting edge. A command with no reply completes on the 48th edge after acceptance, and a missing reply times out on the 112th. A reply whose last bit is sampled on edge L completes on edge L+1, or for class 3 one edge after `dat0_in` is seen high. The bench drives and samples only on falling edges and counts falling edges from its own `start` drive. It checks `done` low on the edge before each of these points, high on the point itself, and reads flags and words there.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int IDX_W     = 6;
    localparam int ARG_W     = 32;
    localparam int CRC_W     = 7;
    localparam int HEAD_W    = 2 + IDX_W + ARG_W;
    localparam int TOKEN_W   = HEAD_W + CRC_W + 1;
    localparam int WORD_W    = 32;
    localparam int N_WORDS   = 4;
    localparam int PAYLOAD_W = N_WORDS * WORD_W;
    localparam int SHORT_W   = HEAD_W + CRC_W + 1;
    localparam int LONG_W    = PAYLOAD_W + 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    typedef enum logic [2:0] {
        RSP_NONE        = 3'd0,
        RSP_SHORT       = 3'd1,
        RSP_SHORT_NOCRC = 3'd2,
        RSP_SHORT_BUSY  = 3'd3,
        RSP_LONG        = 3'd4
    } rsp_class_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TX    = 3'd1,
        ST_WAIT  = 3'd2,
        ST_RX    = 3'd3,
        ST_EVAL  = 3'd4,
        ST_BUSYW = 3'd5
    } fsm_e;

    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
        logic             fb;
        logic [CRC_W-1:0] n;
        fb = b ^ c[CRC_W-1];
        n  = {c[CRC_W-2:0], 1'b0};
        if (fb) n = n ^ CRC_POLY;
        return n;
    endfunction

    function automatic logic [CRC_W-1:0] crc7_block(input logic [HEAD_W-1:0] d);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = HEAD_W - 1; i >= 0; i--) c = crc7_step(c, d[i]);
        return c;
    endfunction

endpackage

// File: rtl/sdc_crc7_acc.sv
module sdc_crc7_acc
    import sdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear)   crc_d = '0;
        else if (en) crc_d = crc7_step(crc_q, bit_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/sdc_tok_ser.sv
module sdc_tok_ser #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] token,
    output logic         line,
    output logic         active,
    output logic         last
);
    localparam int CW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] left;
        logic          act;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        if (load) begin
            ser_d.sh   = token;
            ser_d.left = CW'(W - 1);
            ser_d.act  = 1'b1;
        end else if (ser_q.act) begin
            ser_d.sh = {ser_q.sh[W-2:0], 1'b1};
            if (ser_q.left == '0) ser_d.act  = 1'b0;
            else                  ser_d.left = ser_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '{sh: '1, left: '0, act: 1'b0};
        else        ser_q <= ser_d;
    end

    assign line   = ser_q.act ? ser_q.sh[W-1] : 1'b1;
    assign active = ser_q.act;
    assign last   = ser_q.act && (ser_q.left == '0);
endmodule

// File: rtl/sdc_rsp_deser.sv
module sdc_rsp_deser
    import sdc_pkg::*;
#(
    parameter int W = LONG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift,
    input  logic                 bit_in,
    output logic [1:0]           long_top,
    output logic [PAYLOAD_W-1:0] low
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift) sh_d = {sh_q[W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign long_top = sh_q[W-1 -: 2];
    assign low      = sh_q[PAYLOAD_W-1:0];
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
    import sdc_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic [2:0]        rsp_class,
    input  logic              rsp_in,
    input  logic              dat0_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic              busy,
    output logic              done,
    output logic              err_timeout,
    output logic              err_frame,
    output logic              err_crc,
    output logic [WORD_W-1:0] rsp_w0,
    output logic [WORD_W-1:0] rsp_w1,
    output logic [WORD_W-1:0] rsp_w2,
    output logic [WORD_W-1:0] rsp_w3
);
    localparam int CNT_W = $clog2(LONG_W);
    localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_LAST  = CNT_W'(SHORT_W - 1);
    localparam logic [CNT_W-1:0] LONG_LAST   = CNT_W'(LONG_W - 1);
    localparam logic [CNT_W-1:0] SHORT_CRC_E = CNT_W'(HEAD_W);
    localparam logic [CNT_W-1:0] LONG_CRC_S  = CNT_W'(8);
    localparam logic [CNT_W-1:0] LONG_CRC_E  = CNT_W'(LONG_W - CRC_W - 1);
    localparam logic [TO_W-1:0]  TO_LAST     = TO_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        fsm_e                            st;
        rsp_class_e                      cls;
        logic [CNT_W-1:0]                cnt;
        logic [TO_W-1:0]                 tcnt;
        logic                            done;
        logic                            e_to;
        logic                            e_fr;
        logic                            e_crc;
        logic [N_WORDS-1:0][WORD_W-1:0]  w;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, cls: RSP_NONE, cnt: '0, tcnt: '0,
                                 done: 1'b0, e_to: 1'b0, e_fr: 1'b0, e_crc: 1'b0, w: '0};

    ctl_t ctl_d, ctl_q;

    logic                 tx_load, tx_line, tx_act, tx_last;
    logic                 rx_shift, crc_clear, crc_en;
    logic [1:0]           rx_long_top;
    logic [PAYLOAD_W-1:0] rx_low;
    logic [CRC_W-1:0]     rx_crc;
    logic [HEAD_W-1:0]    tok_head;
    logic [TOKEN_W-1:0]   tok_full;
    rsp_class_e           cls_in;

    assign tok_head = {2'b01, cmd_index, cmd_arg};
    assign tok_full = {tok_head, crc7_block(tok_head), 1'b1};
    assign cls_in   = (rsp_class > 3'(RSP_LONG)) ? RSP_NONE : rsp_class_e'(rsp_class);

    sdc_tok_ser #(.W(TOKEN_W)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tx_load),
        .token  (tok_full),
        .line   (tx_line),
        .active (tx_act),
        .last   (tx_last)
    );

    sdc_rsp_deser #(.W(LONG_W)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift    (rx_shift),
        .bit_in   (rsp_in),
        .long_top (rx_long_top),
        .low      (rx_low)
    );

    sdc_crc7_acc u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (crc_clear),
        .en     (crc_en),
        .bit_in (rsp_in),
        .crc    (rx_crc)
    );

    function automatic logic in_crc_span(input rsp_class_e c, input logic [CNT_W-1:0] idx);
        if (c == RSP_LONG) return (idx >= LONG_CRC_S) && (idx < LONG_CRC_E);
        return idx < SHORT_CRC_E;
    endfunction

    always_comb begin
        logic [1:0] hdr_top;
        logic       bad_frame;
        logic       bad_crc;

        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        tx_load   = 1'b0;
        rx_shift  = 1'b0;
        crc_clear = 1'b0;
        crc_en    = 1'b0;
        hdr_top   = (ctl_q.cls == RSP_LONG) ? rx_long_top : rx_low[SHORT_W-1 -: 2];
        bad_frame = (hdr_top != 2'b00) || !rx_low[0];
        bad_crc   = (rx_low[CRC_W:1] != rx_crc) && (ctl_q.cls != RSP_SHORT_NOCRC);

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    tx_load     = 1'b1;
                    ctl_d.st    = ST_TX;
                    ctl_d.cls   = cls_in;
                    ctl_d.e_to  = 1'b0;
                    ctl_d.e_fr  = 1'b0;
                    ctl_d.e_crc = 1'b0;
                end
            end
            ST_TX: begin
                if (tx_last) begin
                    if (ctl_q.cls == RSP_NONE) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st   = ST_WAIT;
                        ctl_d.tcnt = '0;
                        crc_clear  = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (!rsp_in) begin
                    rx_shift  = 1'b1;
                    crc_en    = in_crc_span(ctl_q.cls, '0);
                    ctl_d.cnt = CNT_W'(1);
                    ctl_d.st  = ST_RX;
                end else if (ctl_q.tcnt == TO_LAST) begin
                    ctl_d.e_to = 1'b1;
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end else begin
                    ctl_d.tcnt = ctl_q.tcnt + 1'b1;
                end
            end
            ST_RX: begin
                rx_shift = 1'b1;
                crc_en   = in_crc_span(ctl_q.cls, ctl_q.cnt);
                if (ctl_q.cnt == ((ctl_q.cls == RSP_LONG) ? LONG_LAST : SHORT_LAST))
                    ctl_d.st = ST_EVAL;
                else
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            ST_EVAL: begin
                if (bad_frame)    ctl_d.e_fr  = 1'b1;
                else if (bad_crc) ctl_d.e_crc = 1'b1;
                for (int k = 0; k < N_WORDS; k++) begin
                    if (ctl_q.cls == RSP_LONG)
                        ctl_d.w[k] = rx_low[PAYLOAD_W-1-k*WORD_W -: WORD_W];
                    else if (k == 0)
                        ctl_d.w[k] = rx_low[SHORT_W-9 -: WORD_W];
                    else
                        ctl_d.w[k] = '0;
                end
                if (ctl_q.cls == RSP_SHORT_BUSY) begin
                    ctl_d.st = ST_BUSYW;
                end else begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            ST_BUSYW: begin
                if (dat0_in) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign cmd_out     = tx_line;
    assign cmd_oe      = tx_act;
    assign busy        = (ctl_q.st != ST_IDLE);
    assign done        = ctl_q.done;
    assign err_timeout = ctl_q.e_to;
    assign err_frame   = ctl_q.e_fr;
    assign err_crc     = ctl_q.e_crc;
    assign rsp_w0      = ctl_q.w[0];
    assign rsp_w1      = ctl_q.w[1];
    assign rsp_w2      = ctl_q.w[2];
    assign rsp_w3      = ctl_q.w[3];
endmodule

// File: rtl/sdc_cmd_engine_chk.sv
module sdc_cmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [2:0] rsp_class,
    input logic       cmd_out,
    input logic       cmd_oe,
    input logic       busy,
    input logic       done,
    input logic       err_timeout,
    input logic       err_frame,
    input logic       err_crc
);
    logic [7:0] oe_len;
    logic [2:0] cls_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_len <= '0;
            cls_q  <= '0;
        end else begin
            oe_len <= cmd_oe ? oe_len + 8'd1 : 8'd0;
            if (start && !busy) cls_q <= (rsp_class > 3'd4) ? 3'd0 : rsp_class;
        end
    end

    AST_TOKEN_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out); // R1
    AST_TOKEN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> (oe_len == 8'd48)); // R1
    AST_TOKEN_END_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> $past(cmd_out)); // R1
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_out); // R2
    AST_NONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls_q == 3'd0) |-> !(err_timeout || err_frame || err_crc)); // R3
    AST_NOCRC_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls_q == 3'd2) |-> !err_crc); // R8
    AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_timeout, err_frame, err_crc})); // R9
    AST_ERR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({err_timeout, err_frame, err_crc})); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R12
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R12
endmodule

bind sdc_cmd_engine sdc_cmd_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rsp_class   (rsp_class),
    .cmd_out     (cmd_out),
    .cmd_oe      (cmd_oe),
    .busy        (busy),
    .done        (done),
    .err_timeout (err_timeout),
    .err_frame   (err_frame),
    .err_crc     (err_crc)
);

// File: tb/sdc_cmd_engine_tb.sv
module sdc_cmd_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic [2:0]  rsp_class = '0;
    logic        rsp_in = 1'b1;
    logic        dat0_in = 1'b1;
    logic        cmd_out, cmd_oe, busy, done, err_timeout, err_frame, err_crc;
    logic [31:0] rsp_w0, rsp_w1, rsp_w2, rsp_w3;

    int n_chk = 0;
    int n_bad = 0;
    logic [127:0] exp_w = '0;

    always #10 clk = ~clk;

    sdc_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .rsp_class(rsp_class), .rsp_in(rsp_in), .dat0_in(dat0_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .done(done),
        .err_timeout(err_timeout), .err_frame(err_frame), .err_crc(err_crc),
        .rsp_w0(rsp_w0), .rsp_w1(rsp_w1), .rsp_w2(rsp_w2), .rsp_w3(rsp_w3)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // remainder of message * x^7 divided by x^7+x^3+1
    function automatic logic [6:0] crc_div(input logic [135:0] v, input int n);
        logic [7:0] r;
        logic       b;
        r = '0;
        for (int i = 0; i < n + 7; i++) begin
            b = (i < n) ? v[n-1-i] : 1'b0;
            r = {r[6:0], b};
            if (r[7]) r = r ^ 8'h89;
        end
        return r[6:0];
    endfunction

    function automatic logic [127:0] words_now();
        return {rsp_w0, rsp_w1, rsp_w2, rsp_w3};
    endfunction

    // fault: 0 clean, 1 bad crc, 2 bad transmission bit, 3 silent card, 4 bad end bit
    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [2:0] cls,
                           input int gap, input int fault, input int bw,
                           input logic [119:0] pl, input bit poke);
        logic [47:0]  tok;
        logic [47:0]  tok_exp;
        logic [39:0]  head;
        logic [135:0] rv;
        logic [127:0] w_new;
        logic [6:0]   c;
        logic [2:0]   ncls;
        int           len;
        int           oe_hi;
        int           early;
        ncls    = (cls > 3'd4) ? 3'd0 : cls;
        head    = {2'b01, idx, arg};
        tok_exp = {head, crc_div({96'b0, head}, 40), 1'b1};
        @(negedge clk);
        start = 1'b1; cmd_index = idx; cmd_arg = arg; rsp_class = cls;
        dat0_in = (ncls == 3'd3) ? 1'b0 : 1'b1;
        @(negedge clk);
        start = 1'b0;
        oe_hi = 0;
        for (int k = 0; k < 48; k++) begin
            if (k > 0) @(negedge clk);
            if (poke && k == 10) begin start = 1'b1; cmd_index = ~idx; rsp_class = 3'd4; end
            if (poke && k == 11) start = 1'b0;
            tok[47-k] = cmd_out;
            if (cmd_oe) oe_hi++;
        end
        chk("R1 token bits", {80'b0, tok}, {80'b0, tok_exp});
        chk("R1 oe cycles", 128'(oe_hi), 128'd48);
        chk("R12 busy during token", {127'b0, busy}, 128'd1);
        if (ncls == 3'd0) begin
            @(negedge clk);
            chk("R3 done after token", {127'b0, done}, 128'd1);
            chk("R3 no error", {125'b0, err_timeout, err_frame, err_crc}, 128'd0);
            chk("R3 words kept", words_now(), exp_w);
            chk("R1 line idle after token", {126'b0, cmd_oe, cmd_out}, 128'd1);
            return;
        end
        if (fault == 3) begin
            early = 0;
            for (int j = 0; j < 64; j++) begin
                @(negedge clk);
                if (done) early++;
            end
            chk("R4 no early done", 128'(early), 128'd0);
            @(negedge clk);
            chk("R4 timeout done", {127'b0, done}, 128'd1);
            chk("R4 timeout flag", {125'b0, err_timeout, err_frame, err_crc}, 128'd4);
            chk("R4 words kept", words_now(), exp_w);
            return;
        end
        if (ncls == 3'd4) begin
            len = 136;
            c = crc_div({16'b0, pl}, 120);
            if (fault == 1) c = c ^ 7'h01;
            rv = {(fault == 2) ? 2'b01 : 2'b00, 6'h3F, pl, c, (fault == 4) ? 1'b0 : 1'b1};
            w_new = rv[127:0];
        end else begin
            len = 48;
            head = {1'b0, (fault == 2), idx, pl[31:0]};
            c = crc_div({96'b0, head}, 40);
            if (fault == 1) c = c ^ 7'h01;
            rv = {88'b0, head, c, (fault == 4) ? 1'b0 : 1'b1};
            w_new = {pl[31:0], 96'b0};
        end
        for (int j = 0; j < gap; j++) @(negedge clk);
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            rsp_in = rv[len-1-j];
        end
        @(negedge clk);
        rsp_in = 1'b1;
        chk("R11 done not before eval", {127'b0, done}, 128'd0);
        @(negedge clk);
        if (ncls == 3'd3) begin
            early = done ? 1 : 0;
            for (int j = 0; j < bw; j++) begin
                @(negedge clk);
                if (done) early++;
            end
            chk("R10 done held while busy", 128'(early), 128'd0);
            dat0_in = 1'b1;
            @(negedge clk);
            chk("R10 done on release", {127'b0, done}, 128'd1);
        end else begin
            chk("R11 done latency", {127'b0, done}, 128'd1);
        end
        chk("R12 busy low at done", {127'b0, busy}, 128'd0);
        if (fault == 2 || fault == 4)
            chk("R7 frame error", {125'b0, err_timeout, err_frame, err_crc}, 128'd2);
        else if (fault == 1 && ncls != 3'd2)
            chk("R8 crc error", {125'b0, err_timeout, err_frame, err_crc}, 128'd1);
        else
            chk("R8 R9 no error", {125'b0, err_timeout, err_frame, err_crc}, 128'd0);
        if (ncls == 3'd4) chk("R6 long words", words_now(), w_new);
        else              chk("R5 short words", words_now(), w_new);
        exp_w = w_new;
        @(negedge clk);
        chk("R11 done single cycle", {127'b0, done}, 128'd0);
    endtask

    function automatic logic [119:0] rnd_pl();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] ecls;
        void'($urandom(32'h5EED_0C0D));
        repeat (3) @(negedge clk);
        chk("R2 reset outputs", {120'b0, cmd_out, cmd_oe, busy, done, err_timeout, err_frame, err_crc, 1'b0},
            {120'b0, 8'b1000_0000});
        chk("R2 reset words", words_now(), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_cmd(6'd0, 32'h0, 3'd0, 0, 0, 0, '0, 1'b0);                        // R3 no reply
        run_cmd(6'd17, 32'h0000_0200, 3'd1, 0, 0, 0, rnd_pl(), 1'b0);          // R5 gap 0
        run_cmd(6'd41, 32'h40FF_8000, 3'd2, 5, 1, 0, rnd_pl(), 1'b0);          // R8 nocrc ignores
        run_cmd(6'd13, 32'h1234_0000, 3'd1, 3, 1, 0, rnd_pl(), 1'b0);          // R8 crc error
        run_cmd(6'd2,  32'h0, 3'd4, 2, 0, 0, rnd_pl(), 1'b0);                  // R6 long
        run_cmd(6'd9,  32'hABCD_0000, 3'd4, 1, 1, 0, rnd_pl(), 1'b0);          // R8 long crc
        run_cmd(6'd10, 32'h5555_0000, 3'd4, 4, 2, 0, rnd_pl(), 1'b0);          // R7 long frame
        run_cmd(6'd8,  32'h0000_01AA, 3'd1, 0, 3, 0, rnd_pl(), 1'b0);          // R4 timeout
        run_cmd(6'd55, 32'hDEAD_BEEF, 3'd1, 63, 0, 0, rnd_pl(), 1'b0);         // R4 last slot
        run_cmd(6'd7,  32'h0001_0000, 3'd3, 2, 0, 6, rnd_pl(), 1'b0);          // R10 busy
        run_cmd(6'd12, 32'h0, 3'd6, 0, 0, 0, '0, 1'b0);                        // R3 code 6 -> none
        run_cmd(6'd18, 32'h0000_0010, 3'd1, 1, 0, 0, rnd_pl(), 1'b1);          // R12 start ignored
        run_cmd(6'd6,  32'h03B9_0100, 3'd1, 2, 4, 0, rnd_pl(), 1'b0);          // R7 end bit

        @(negedge clk);
        chk("R9 flags held in idle", {125'b0, err_timeout, err_frame, err_crc}, 128'd2);

        for (int t = 0; t < 40; t++) begin
            ecls = 3'($urandom() % 7);
            run_cmd(6'($urandom()), $urandom(), ecls, int'($urandom() % 64),
                    int'($urandom() % 5), int'($urandom() % 8), rnd_pl(), 1'b0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule